// File: doc/BRIEF.md
# Sample-and-Hold DAC Refresh Sequencer

This block keeps four analog control voltages alive. Each voltage sits on a sample-and-hold amplifier that drifts unless it is reloaded now and then. One 12-bit DAC and an 8-to-1 analog multiplexer are shared across the four holds. The block stores a 12-bit target code for each channel, and the host writes these codes through a one-cycle write port. On each periodic tick, nominally every 2 ms, the block reloads the next channel in rotation. Each channel is therefore renewed every 8 ms.

A reload is a fixed four-step bus sequence on two 8-bit ports: a latch that drives the multiplexer, and the DAC data port with its load strobe.

- The latch carries an inhibit bit, the channel address and the low nibble of the code.
- The DAC port carries the high byte of the code.
- The multiplexer is blanked before the DAC value changes and released afterwards, so a hold never sees a half-updated code.

Channel 0 is square-wave symmetry, channel 1 is square-wave amplitude, channel 2 is output offset and channel 3 is waveform amplitude. While square-wave output is deselected, channel 1 is driven with code 0, which is the -5 V end of the DAC range (code 4095 is +5 V).

Top module: `sh_refresh_seq`

## Requirements
- R1: During and right after reset, the latch image is 0x80 (inhibit set, address 0, nibble 0), with `latch_wr`, `dac_stb` and `busy` low. The channel pointer starts at channel 0.
- R2: A `tick` sampled while idle starts a refresh. In the next cycle `busy` is high and the latch is written with 0x80.
- R3: In the second step the latch is written with bit 7 = 1, bits 6:4 = channel address and bits 3:0 = code bits 3:0.
- R4: In the third step `dac_stb` pulses with `dac_data` = code bits 11:4, with no latch write in that cycle. `dac_data` then holds that value.
- R5: In the fourth step the latch is written with bit 7 = 0, keeping the address and nibble of step two.
- R6: `busy` is high for exactly the four step cycles, then returns low.
- R7: Successive refreshes visit channel addresses 0, 1, 2, 3, 0, ... in that order.
- R8: A `tick` that arrives while `busy` is high is ignored. It neither lengthens the sequence nor skips a channel.
- R9: While `square_sel` is low, a refresh of channel 1 uses code 0 whatever is stored for it. Other channels are unaffected, and the stored value returns once `square_sel` is high.
- R10: A host write lands in the channel register at the clock edge. The code used by a refresh is captured on its start edge, so a write during a sequence does not alter it and appears at that channel's next refresh.
- R11: `dac_stb` and `latch_wr` are never high together, and the latch inhibit bit is set whenever `dac_stb` is high.
- R12: Every code from 0 to 4095 is reproduced exactly across the nibble and the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Periodic refresh request, one cycle |
| square_sel | input | 1 | High when square-wave output is selected |
| wr_en | input | 1 | Host write enable |
| wr_chan | input | 2 | Channel written by the host |
| wr_data | input | 12 | Code written by the host |
| latch_bus | output | 8 | Latch image: inhibit, address, low nibble |
| latch_wr | output | 1 | Latch write strobe |
| dac_data | output | 8 | High byte of the DAC code |
| dac_stb | output | 1 | DAC load strobe |
| busy | output | 1 | High while a refresh sequence runs |

## Verification
The hardest case to reach from the ports is a host write to the very channel being refreshed, landing after the code has been captured but before the DAC byte goes out. The bench reaches it by issuing the write during the first step of a sequence. It then confirms that steps two to four still carry the old code, and that the refresh four ticks later carries the new one. In the same runs the bench holds `tick` high for the whole sequence, so the ignored-tick and capture paths are exercised together. Alongside this, every 12-bit code is swept through the rotating channels.

// File: rtl/sh_refresh_pkg.sv
// Shared definitions for the sample-and-hold refresh sequencer.
// Assumes one refresh step per clock cycle.
package sh_refresh_pkg;

    // Sequence step currently presented on the output ports
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_MUTE   = 3'd1,
        ST_SETUP  = 3'd2,
        ST_LOAD   = 3'd3,
        ST_UNMUTE = 3'd4
    } step_t;

endpackage

// File: rtl/sh_code_bank.sv
// Holds one target code per channel, written by the host.
// The read port is combinational. It forces the square-amplitude channel
// to code 0 while square-wave output is deselected.
// Assumes writes and reads are in the same clock domain.
module sh_code_bank #(
    parameter int NCH    = 4,
    parameter int CODE_W = 12,
    parameter int SQ_CH  = 1,
    localparam int CH_W  = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic [CODE_W-1:0] wr_data,
    input  logic [CH_W-1:0]   rd_chan,
    input  logic              square_sel,
    output logic [CODE_W-1:0] rd_code
);

    logic [CODE_W-1:0] codes [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_reg
        // Store the host's code for channel i
        always_ff @(posedge clk) begin
            if (!rst_n)
                codes[i] <= '0;
            else if (wr_en && wr_chan == CH_W'(i))
                codes[i] <= wr_data;
        end
    end

    // Select the pointed channel, applying the square-wave override
    always_comb begin
        if (rd_chan == CH_W'(SQ_CH) && !square_sel)
            rd_code = '0;
        else
            rd_code = codes[rd_chan];
    end

endmodule

// File: rtl/sh_step_fsm.sv
// Runs the four-step refresh of one channel per accepted tick:
// mute the multiplexer, set address and low nibble, load the DAC high part,
// then unmute. The code is captured on the start edge and the channel
// pointer advances after the final step.
// Assumes tick is a single-cycle pulse; ticks while busy are dropped.
module sh_step_fsm
    import sh_refresh_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CODE_W = 12,
    parameter int LO_W   = 4,
    parameter int ADDR_W = 3,
    localparam int CH_W  = $clog2(NCH),
    localparam int HI_W  = CODE_W - LO_W,
    localparam int LAT_W = 1 + ADDR_W + LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CODE_W-1:0] rd_code,
    output logic [CH_W-1:0]   chan_ptr,
    output logic [LAT_W-1:0]  latch_bus,
    output logic              latch_wr,
    output logic [HI_W-1:0]   dac_data,
    output logic              dac_stb,
    output logic              busy
);

    step_t             state;
    logic [CODE_W-1:0] snap;
    logic [ADDR_W-1:0] addr;

    assign addr = ADDR_W'(chan_ptr);
    assign busy = (state != ST_IDLE);

    // Step through the sequence and drive the latch and DAC ports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            chan_ptr  <= '0;
            snap      <= '0;
            latch_bus <= {1'b1, {(LAT_W-1){1'b0}}};
            latch_wr  <= 1'b0;
            dac_data  <= '0;
            dac_stb   <= 1'b0;
        end else begin
            latch_wr <= 1'b0;
            dac_stb  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (tick) begin
                        snap      <= rd_code;
                        latch_bus <= {1'b1, {(LAT_W-1){1'b0}}};
                        latch_wr  <= 1'b1;
                        state     <= ST_MUTE;
                    end
                end
                ST_MUTE: begin
                    latch_bus <= {1'b1, addr, snap[LO_W-1:0]};
                    latch_wr  <= 1'b1;
                    state     <= ST_SETUP;
                end
                ST_SETUP: begin
                    dac_data <= snap[CODE_W-1:LO_W];
                    dac_stb  <= 1'b1;
                    state    <= ST_LOAD;
                end
                ST_LOAD: begin
                    latch_bus <= {1'b0, addr, snap[LO_W-1:0]};
                    latch_wr  <= 1'b1;
                    state     <= ST_UNMUTE;
                end
                ST_UNMUTE: begin
                    chan_ptr <= (chan_ptr == CH_W'(NCH-1)) ? '0 : chan_ptr + 1'b1;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sh_refresh_seq.sv
// Top of the sample-and-hold refresh sequencer: a per-channel code bank
// feeding a step sequencer that drives one shared DAC and multiplexer latch.
// Assumes a synchronous active-low reset and a single clock.
module sh_refresh_seq #(
    parameter int NCH    = 4,
    parameter int CODE_W = 12,
    parameter int LO_W   = 4,
    parameter int ADDR_W = 3,
    parameter int SQ_CH  = 1,
    localparam int CH_W  = $clog2(NCH),
    localparam int HI_W  = CODE_W - LO_W,
    localparam int LAT_W = 1 + ADDR_W + LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              square_sel,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic [CODE_W-1:0] wr_data,
    output logic [LAT_W-1:0]  latch_bus,
    output logic              latch_wr,
    output logic [HI_W-1:0]   dac_data,
    output logic              dac_stb,
    output logic              busy
);

    logic [CH_W-1:0]   chan_ptr;
    logic [CODE_W-1:0] rd_code;

    sh_code_bank #(.NCH(NCH), .CODE_W(CODE_W), .SQ_CH(SQ_CH)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_chan    (wr_chan),
        .wr_data    (wr_data),
        .rd_chan    (chan_ptr),
        .square_sel (square_sel),
        .rd_code    (rd_code)
    );

    sh_step_fsm #(.NCH(NCH), .CODE_W(CODE_W), .LO_W(LO_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rd_code   (rd_code),
        .chan_ptr  (chan_ptr),
        .latch_bus (latch_bus),
        .latch_wr  (latch_wr),
        .dac_data  (dac_data),
        .dac_stb   (dac_stb),
        .busy      (busy)
    );

endmodule

// File: rtl/sh_refresh_chk.sv
// Protocol checker for the refresh sequencer's port behaviour.
// Assumes the inhibit bit is the top bit of the latch image.
module sh_refresh_chk #(
    parameter int LAT_W = 8,
    parameter int HI_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             busy,
    input logic [LAT_W-1:0] latch_bus,
    input logic             latch_wr,
    input logic [HI_W-1:0]  dac_data,
    input logic             dac_stb
);

    localparam logic [LAT_W-1:0] MUTE_WORD = {1'b1, {(LAT_W-1){1'b0}}};

    // R11
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dac_stb && latch_wr));

    // R11
    load_while_muted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_stb |-> latch_bus[LAT_W-1]);

    // R2
    start_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !busy) |=> (busy && latch_wr && latch_bus == MUTE_WORD));

    // R3
    setup_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_wr && latch_bus == MUTE_WORD && !$past(latch_wr))
        |=> (latch_wr && latch_bus[LAT_W-1]));

    // R5
    unmute_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_stb |=> (latch_wr && !latch_bus[LAT_W-1]
                     && latch_bus[LAT_W-2:0] == $past(latch_bus[LAT_W-2:0])));

    // R4
    dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_stb |=> $stable(dac_data));

    // R6
    end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_wr && !latch_bus[LAT_W-1]) |=> !busy);

endmodule

bind sh_refresh_seq sh_refresh_chk #(.LAT_W(LAT_W), .HI_W(HI_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .busy      (busy),
    .latch_bus (latch_bus),
    .latch_wr  (latch_wr),
    .dac_data  (dac_data),
    .dac_stb   (dac_stb)
);

// File: tb/sh_refresh_seq_test.sv
`timescale 1ns/1ps
module sh_refresh_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        square_sel = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_chan = '0;
    logic [11:0] wr_data = '0;
    logic [7:0]  latch_bus;
    logic        latch_wr;
    logic [7:0]  dac_data;
    logic        dac_stb;
    logic        busy;

    int checks = 0;
    int errors = 0;
    int exp_ptr = 0;
    logic [11:0] model [4];

    always #2 clk = ~clk;

    sh_refresh_seq uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .square_sel(square_sel),
        .wr_en(wr_en), .wr_chan(wr_chan), .wr_data(wr_data),
        .latch_bus(latch_bus), .latch_wr(latch_wr), .dac_data(dac_data),
        .dac_stb(dac_stb), .busy(busy)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // Compare busy, latch strobe, DAC strobe and latch image at once
    task automatic step_check(input string req, input logic [7:0] lat,
                              input logic lwr, input logic stb, input logic bsy);
        check(req, {bsy == busy ? 1'b0 : 1'b1, 20'd0, busy, latch_wr, dac_stb, latch_bus},
                   {1'b0, 20'd0, bsy, lwr, stb, lat});
    endtask

    task automatic host_write(input int ch, input logic [11:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_chan = 2'(ch); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        model[ch] = v;
    endtask

    // One refresh; hold keeps tick high throughout, mid writes nv during step 1
    task automatic refresh(input string req, input bit hold, input bit mid, input logic [11:0] nv);
        int ch;
        logic [11:0] c;
        logic [2:0] a;
        ch = exp_ptr;
        c = (ch == 1 && !square_sel) ? 12'd0 : model[ch];
        a = 3'(ch);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = hold;
        step_check({req, "/R2"}, 8'h80, 1'b1, 1'b0, 1'b1);
        if (mid) begin wr_en = 1'b1; wr_chan = 2'(ch); wr_data = nv; end
        @(negedge clk);
        if (mid) begin wr_en = 1'b0; model[ch] = nv; end
        step_check({req, "/R3/R7"}, {1'b1, a, c[3:0]}, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        step_check({req, "/R4"}, {1'b1, a, c[3:0]}, 1'b0, 1'b1, 1'b1);
        check({req, "/R4 dac"}, 32'(dac_data), 32'(c[11:4]));
        @(negedge clk);
        step_check({req, "/R5"}, {1'b0, a, c[3:0]}, 1'b1, 1'b0, 1'b1);
        @(negedge clk) tick = 1'b0;
        step_check({req, hold ? "/R8" : "/R6"}, {1'b0, a, c[3:0]}, 1'b0, 1'b0, 1'b0);
        check({req, "/R4 hold"}, 32'(dac_data), 32'(c[11:4]));
        exp_ptr = (exp_ptr + 1) % 4;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) model[i] = '0;
        tick = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state, with tick held during reset
        step_check("R1", 8'h80, 1'b0, 1'b0, 1'b0);
        tick = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        step_check("R1 after", 8'h80, 1'b0, 1'b0, 1'b0);

        // R7 rotation from channel 0 with zero codes
        for (int i = 0; i < 4; i++) refresh("R7", 1'b0, 1'b0, 12'd0);

        // R12 full code sweep across rotating channels
        for (int v = 0; v < 4096; v++) begin
            host_write(exp_ptr, 12'(v));
            refresh((v == 0 || v == 4095) ? "R12 edge" : "R12", 1'b0, 1'b0, 12'd0);
        end

        // R8 ticks held high through sequences; R10 write during sequence
        host_write(0, 12'h5A3); host_write(1, 12'h1C7);
        host_write(2, 12'hE09); host_write(3, 12'h3F0);
        for (int i = 0; i < 4; i++)
            refresh("R8/R10 mid", 1'b1, 1'b1, 12'(12'hA55 ^ (i * 12'h111)));
        for (int i = 0; i < 4; i++) refresh("R10 next", 1'b0, 1'b0, 12'd0);

        // R9 square override on channel 1 only, then restored
        host_write(1, 12'hABC);
        square_sel = 1'b0;
        for (int i = 0; i < 4; i++) refresh("R9 off", 1'b0, 1'b0, 12'd0);
        square_sel = 1'b1;
        for (int i = 0; i < 4; i++) refresh("R9 on", 1'b0, 1'b0, 12'd0);

        // R8 back-to-back ticks: the second pulse lands while busy
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        repeat (4) @(negedge clk);
        step_check("R8 single", latch_bus, 1'b0, 1'b0, 1'b0);
        exp_ptr = (exp_ptr + 1) % 4;
        refresh("R8 rotation", 1'b0, 1'b0, 12'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule